// File: doc/BRIEF.md
# Atomic 16-bit Counter with Byte-Wide Access

This block holds a 16-bit up-counter and three further 16-bit words (two compare values and one capture value) behind an 8-bit register bus. A processor with a byte-wide data path moves each word as two single-byte accesses. One shared byte holding latch makes every 16-bit transfer atomic. On a write, the upper byte is staged in the latch first, and the lower byte then commits the whole word in one cycle. On a read, fetching the lower byte freezes the upper byte in the latch, so a later fetch of the upper byte matches it even if the counter has carried in between.

The counter advances by one on each cycle in which the prescaler's enable is high, and it wraps at the top of its range. The capture word takes a snapshot of the counter when a strobe input is high. The bus can read it but cannot write it. The compare words are plain storage that follow the same two-step write and read order as the counter.

Top module: `cnt16_bytebus`

## Requirements
- R1: After reset the counter, both compare words, the capture word and the holding latch are all zero.
- R2: A write with hi_sel_i=1 to any word except the capture word (reg_sel_i=3) loads wdata_i into the holding latch and leaves the stored words unchanged.
- R3: A write with hi_sel_i=0 to a writable word stores {latch, wdata_i} into that word at the clock edge. reg_sel_i selects the word: 0 counter, 1 compare A, 2 compare B.
- R4: A read with hi_sel_i=0 returns the selected word's live low byte on rdata_o in the same cycle, and at the edge it copies that word's live high byte into the latch.
- R5: A read with hi_sel_i=1 returns the latch contents, whatever the live high byte of the selected word is.
- R6: When a low-byte write to the counter and cnt_en_i fall in the same cycle, the written value is stored and the increment is dropped.
- R7: With cnt_en_i high, the counter steps from 0xFFFF to 0x0000.
- R8: All four words share the single holding latch, so a high byte staged through one word's address is used by a low-byte write to another word.
- R9: Writes to the capture word (reg_sel_i=3) change neither the capture word nor the latch. When cap_stb_i is high, the capture word takes the counter value from before that edge.
- R10: With cnt_en_i high and no counter load, the counter grows by exactly one per cycle, and it holds its value while cnt_en_i is low.
- R11: rdata_o is zero in every cycle without a read access (cs_i=0 or we_i=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| reg_sel_i | input | 2 | Word select: 0 counter, 1 compare A, 2 compare B, 3 capture |
| hi_sel_i | input | 1 | 1 = upper byte, 0 = lower byte |
| wdata_i | input | 8 | Write data |
| cnt_en_i | input | 1 | Count pulse from the prescaler |
| cap_stb_i | input | 1 | Snapshot counter into the capture word |
| rdata_o | output | 8 | Read data, valid in the cycle of the read access |

## Verification
The bench goes after the carry race. It reads the low byte at 0x00FF while the counter steps to 0x0100 and expects 0x00 from the later high-byte read. A design that returned the live high byte would give the torn value 0x01FF. It also loads the counter while an enable pulse is present, which catches a design that increments after the load. It steps the counter across 0xFFFF to expose a lost or sticky wrap. It stages a high byte through one word and commits it through another, which shows up a design with a separate latch per word. Finally, it writes to the capture address, which exposes a design that lets those writes reach the capture word or the latch.

// File: rtl/cnt16_pkg.sv
package cnt16_pkg;
  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_CMPA = 2'd1,
    SEL_CMPB = 2'd2,
    SEL_CAP  = 2'd3
  } reg_sel_e;
  localparam int unsigned NUM_CMP = 2;
endpackage

// File: rtl/cnt16_hold.sv
module cnt16_hold #(
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [BW-1:0] d_i,
  output logic [BW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/cnt16_word.sv
module cnt16_word #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/cnt16_ctr.sv
module cnt16_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  input  logic         en_i,
  output logic [W-1:0] q_o
);
  // bus load wins over a count pulse in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
    else if (en_i) q_o <= q_o + W'(1);
  end
endmodule

// File: rtl/cnt16_bytebus.sv
module cnt16_bytebus
  import cnt16_pkg::*;
#(
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic          hi_sel_i,
  input  logic [BW-1:0] wdata_i,
  input  logic          cnt_en_i,
  input  logic          cap_stb_i,
  output logic [BW-1:0] rdata_o
);
  localparam int unsigned W = 2 * BW;
  localparam int unsigned NW = NUM_CMP + 2;

  reg_sel_e      sel;
  logic          rd_acc, wr_acc, wr_lo, sel_cap;
  logic          tmp_ld;
  logic [BW-1:0] tmp_d, tmp_q;
  logic [W-1:0]  full_w, cnt_q, cap_q, word_sel;
  logic [W-1:0]  words [NW];

  assign sel     = reg_sel_e'(reg_sel_i);
  assign rd_acc  = cs_i & ~we_i;
  assign wr_acc  = cs_i & we_i;
  assign sel_cap = (sel == SEL_CAP);
  assign wr_lo   = wr_acc & ~hi_sel_i & ~sel_cap;
  assign full_w  = {tmp_q, wdata_i};
  assign word_sel = words[reg_sel_i];

  // latch: staged high byte on write, frozen live high byte on low read
  assign tmp_ld = (wr_acc & hi_sel_i & ~sel_cap) | (rd_acc & ~hi_sel_i);
  assign tmp_d  = wr_acc ? wdata_i : word_sel[W-1:BW];

  cnt16_hold #(.BW(BW)) u_hold (
    .clk_i (clk_i), .rst_ni(rst_ni), .ld_i(tmp_ld), .d_i(tmp_d), .q_o(tmp_q)
  );

  cnt16_ctr #(.W(W)) u_ctr (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .ld_i  (wr_lo & (sel == SEL_CNT)),
    .d_i   (full_w), .en_i(cnt_en_i), .q_o(cnt_q)
  );
  assign words[0] = cnt_q;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    logic [W-1:0] q;
    cnt16_word #(.W(W)) u_cmp (
      .clk_i (clk_i), .rst_ni(rst_ni),
      .ld_i  (wr_lo & (reg_sel_i == 2'(g + 1))),
      .d_i   (full_w), .q_o(q)
    );
    assign words[g+1] = q;
  end

  cnt16_word #(.W(W)) u_cap (
    .clk_i (clk_i), .rst_ni(rst_ni), .ld_i(cap_stb_i), .d_i(cnt_q), .q_o(cap_q)
  );
  assign words[NW-1] = cap_q;

  assign rdata_o = !rd_acc  ? '0 :
                   hi_sel_i ? tmp_q : word_sel[BW-1:0];
endmodule

// File: rtl/cnt16_bytebus_chk.sv
module cnt16_bytebus_chk #(
  parameter int unsigned BW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cs_i,
  input logic            we_i,
  input logic [1:0]      reg_sel_i,
  input logic            hi_sel_i,
  input logic [BW-1:0]   wdata_i,
  input logic            cnt_en_i,
  input logic            cap_stb_i,
  input logic [BW-1:0]   rdata_o,
  input logic [2*BW-1:0] cnt_q,
  input logic [BW-1:0]   tmp_q,
  input logic [2*BW-1:0] cap_q
);
  localparam int unsigned W = 2 * BW;

  a_r2_hi_wr_keeps_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && hi_sel_i && !cnt_en_i) |=> (cnt_q == $past(cnt_q)));

  // R3 and R6: load stored even with a count pulse present
  a_r3_lo_wr_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && !hi_sel_i && reg_sel_i == 2'd0)
      |=> (cnt_q == {$past(tmp_q), $past(wdata_i)}));

  a_r4_lo_rd_freezes_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && !hi_sel_i && reg_sel_i == 2'd0)
      |=> (tmp_q == $past(cnt_q[W-1:BW])));

  a_r5_hi_rd_gives_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && hi_sel_i) |-> (rdata_o == tmp_q));

  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && cnt_q == '1 && !(cs_i && we_i && !hi_sel_i && reg_sel_i == 2'd0))
      |=> (cnt_q == '0));

  a_r9_cap_only_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_stb_i |=> $stable(cap_q));

  a_r11_idle_bus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && !we_i) |-> (rdata_o == '0));
endmodule

bind cnt16_bytebus cnt16_bytebus_chk #(.BW(BW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i),
  .reg_sel_i(reg_sel_i), .hi_sel_i(hi_sel_i), .wdata_i(wdata_i),
  .cnt_en_i(cnt_en_i), .cap_stb_i(cap_stb_i), .rdata_o(rdata_o),
  .cnt_q(cnt_q), .tmp_q(tmp_q), .cap_q(cap_q)
);

// File: tb/cnt16_bytebus_tb.sv
module cnt16_bytebus_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_i = 1'b0, we_i = 1'b0, hi_sel_i = 1'b0;
  logic [1:0] reg_sel_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic       cnt_en_i = 1'b0, cap_stb_i = 1'b0;
  logic [7:0] rdata_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural reference: four words and the latch
  int m_word [4];
  int m_tmp;

  always #2.5 clk_i = ~clk_i;

  cnt16_bytebus u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i),
    .reg_sel_i(reg_sel_i), .hi_sel_i(hi_sel_i), .wdata_i(wdata_i),
    .cnt_en_i(cnt_en_i), .cap_stb_i(cap_stb_i), .rdata_o(rdata_o)
  );

  function automatic int model_rd();
    if (!(cs_i && !we_i)) return 0;
    if (hi_sel_i) return m_tmp;
    return m_word[reg_sel_i] & 8'hFF;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_word[i]) m_word[i] = 0;
      m_tmp = 0;
    end else begin
      int old_cnt, old_tmp;
      bit cnt_loaded;
      old_cnt = m_word[0];
      old_tmp = m_tmp;
      cnt_loaded = 0;
      if (cs_i && we_i && reg_sel_i != 2'd3) begin
        if (hi_sel_i) m_tmp = wdata_i;
        else begin
          m_word[reg_sel_i] = old_tmp * 256 + wdata_i;
          if (reg_sel_i == 2'd0) cnt_loaded = 1;
        end
      end else if (cs_i && !we_i && !hi_sel_i) begin
        m_tmp = (m_word[reg_sel_i] >> 8) & 8'hFF;
      end
      if (!cnt_loaded && cnt_en_i) m_word[0] = (old_cnt + 1) % 65536;
      if (cap_stb_i) m_word[3] = old_cnt;
    end
  end

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus cycle; rdata compared to the model every cycle
  task automatic cyc(input bit cs, input bit we, input int sel, input bit hi,
                     input int wd, input bit en, input bit stb, input string req);
    @(negedge clk_i);
    cs_i = cs; we_i = we; reg_sel_i = 2'(sel); hi_sel_i = hi;
    wdata_i = 8'(wd); cnt_en_i = en; cap_stb_i = stb;
    #1;
    check(int'(rdata_o), model_rd(), (cs && !we) ? req : "R11");
  endtask

  task automatic wr(input int sel, input bit hi, input int wd, input string req);
    cyc(1, 1, sel, hi, wd, 0, 0, req);
  endtask

  task automatic rd(input int sel, input bit hi, input int exp, input string req);
    cyc(1, 0, sel, hi, 0, 0, 0, req);
    check(int'(rdata_o), exp, req);
  endtask

  task automatic idle(input bit en, input bit stb);
    cyc(0, 0, 0, 0, 0, en, stb, "R11");
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(s, 0, 8'h00, "R1");
      rd(s, 1, 8'h00, "R1");
    end
    // R2 high write stages only
    wr(0, 1, 8'hA5, "R2");
    rd(0, 0, 8'h00, "R2");
    rd(0, 1, 8'h00, "R2");
    // R3 full write
    wr(0, 1, 8'h12, "R3");
    wr(0, 0, 8'h34, "R3");
    rd(0, 0, 8'h34, "R3");
    rd(0, 1, 8'h12, "R3");
    // R5 high read gives latch, not live byte
    wr(0, 1, 8'h77, "R5");
    rd(0, 1, 8'h77, "R5");
    // R10 count and hold
    repeat (5) idle(1, 0);
    repeat (3) idle(0, 0);
    rd(0, 0, 8'h39, "R10");
    rd(0, 1, 8'h12, "R10");
    // R4 carry race: low read at 0x00FF with a pulse in the same cycle
    wr(0, 1, 8'h00, "R4");
    wr(0, 0, 8'hFF, "R4");
    cyc(1, 0, 0, 0, 0, 1, 0, "R4");
    check(int'(rdata_o), 8'hFF, "R4");
    rd(0, 1, 8'h00, "R4");
    rd(0, 0, 8'h00, "R4");
    rd(0, 1, 8'h01, "R4");
    // R6 load beats pulse
    wr(0, 1, 8'hBE, "R6");
    cyc(1, 1, 0, 0, 8'hEF, 1, 0, "R6");
    rd(0, 0, 8'hEF, "R6");
    rd(0, 1, 8'hBE, "R6");
    // R7 wrap
    wr(0, 1, 8'hFF, "R7");
    wr(0, 0, 8'hFE, "R7");
    idle(1, 0);
    idle(1, 0);
    rd(0, 0, 8'h00, "R7");
    rd(0, 1, 8'h00, "R7");
    // R8 latch shared across words
    wr(1, 1, 8'h5A, "R8");
    wr(2, 0, 8'h11, "R8");
    rd(2, 0, 8'h11, "R8");
    rd(2, 1, 8'h5A, "R8");
    rd(1, 0, 8'h00, "R8");
    rd(1, 1, 8'h00, "R8");
    wr(1, 1, 8'hC3, "R3");
    wr(1, 0, 8'h3C, "R3");
    rd(1, 0, 8'h3C, "R3");
    rd(1, 1, 8'hC3, "R3");
    // R9 capture snapshot and write immunity
    wr(0, 1, 8'h42, "R9");
    wr(0, 0, 8'h24, "R9");
    idle(1, 1);
    wr(3, 1, 8'h99, "R9");
    wr(3, 0, 8'h66, "R9");
    rd(3, 1, 8'h42, "R9");
    rd(3, 0, 8'h24, "R9");
    rd(3, 1, 8'h42, "R9");
    rd(0, 0, 8'h25, "R9");
    idle(0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule